// File: doc/BRIEF.md
# Binary Extension Field Multiplier

This block multiplies two elements of GF(2^m) held in polynomial basis and returns their product reduced by a fixed irreducible polynomial. The field size `M` and the reduction polynomial `TAPS` are set at build time. Bit `k` of each operand and of the result is the coefficient of x^k, so bit 0 is the constant term. The core is a network of two-input AND and XOR gates. The partial products are ANDed, each product coefficient is collapsed by a balanced XOR tree, and the upper half of the raw product is folded back through a fold map that is computed at elaboration. A sparse trinomial or pentanomial therefore adds only a few XOR levels. No iterative shift-and-add loop is used.

`TAPS` holds the polynomial without its leading x^M term: bit `k` of `TAPS` is the coefficient of x^k. The supported builds are listed below.

| Build | Polynomial | `TAPS` |
|---|---|---|
| M=6 | x^6+x^3+1 | 0x09 |
| M=7 | x^7+x^4+1 | 0x11 |
| M=7 | x^7+x^3+1 | 0x09 |
| M=8 | x^8+x^4+x^3+x+1 | 0x1B |

An output stage follows the core. With `REG_OUT=1` it registers the result and the valid flag. With `REG_OUT=0` the core stays combinational and only the valid flag is gated by reset.

Top module: `gf2m_mult_top`

## Requirements
- R1: With M=8 and TAPS=0x1B (x^8+x^4+x^3+x+1), `c_o` equals the carry-less product of `a_i` and `b_i` reduced modulo that polynomial.
- R2: With M=6 and TAPS=0x09 (x^6+x^3+1), `c_o` equals the reduced product for every one of the 4096 operand pairs.
- R3: With M=7 and TAPS=0x11 (x^7+x^4+1), `c_o` equals the reduced product for every operand pair.
- R4: With M=7 and TAPS=0x09 (x^7+x^3+1), `c_o` equals the reduced product for every operand pair.
- R5: Bit k of every operand and of the result is the coefficient of x^k. With M=8 and TAPS=0x1B, 0x57 times 0x83 gives 0xC1, and 0x57 times 0x13 gives 0xFE.
- R6: If either operand is zero, the result is zero.
- R7: If one operand equals 1 (only bit 0 set), the result equals the other operand.
- R8: Swapping the operands does not change the result.
- R9: With REG_OUT=1, a pair presented with `in_valid` high at a rising edge shows up on `c_o` after that edge, with `out_valid` high for one cycle.
- R10: With REG_OUT=1, when `in_valid` is low at a rising edge, `c_o` keeps its value and `out_valid` is low after that edge, whatever the operands are.
- R11: While `rst_n` is low, `out_valid` is low and a registered `c_o` is zero. After `rst_n` rises, the reset is released in step with the clock. `out_valid` stays low after the first rising edge. In the combinational build it follows `in_valid` from the second rising edge on. In the registered build it first goes high after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| a_i | input | M | First operand; bit k is the coefficient of x^k |
| b_i | input | M | Second operand; bit k is the coefficient of x^k |
| out_valid | output | 1 | Result on `c_o` is valid |
| c_o | output | M | Reduced product |

## Verification
The bench builds three combinational instances: M=6 with TAPS=0x09, and M=7 with TAPS=0x11 and with TAPS=0x09. Their operands are swept through every pair, so every fold row of the three sparse polynomials and every zero and unit case is covered exhaustively. A fourth instance uses M=8 with TAPS=0x1B and the registered output stage. It brings within reach the known vectors, random pairs with swapped operands, the capture-enable hold, and the cycle-exact release of reset.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;

  // One row of the fold map: x^(M+j) mod P, for M up to 31.
  typedef logic [31:0] gf_row_t;

  // Residue of x^(m+j) modulo x^m + taps, computed by repeated doubling.
  function automatic gf_row_t fold_row(int m, gf_row_t taps, int j);
    gf_row_t r;
    gf_row_t mask;
    logic    carry;
    mask = (gf_row_t'(1) << m) - gf_row_t'(1);
    r    = taps & mask;
    for (int s = 0; s < j; s++) begin
      carry = r[m-1];
      r     = (r << 1) & mask;
      if (carry) r = r ^ (taps & mask);
    end
    return r;
  endfunction

  // Lowest operand index that contributes to product coefficient k.
  function automatic int pp_lo(int k, int m);
    return (k > m - 1) ? (k - m + 1) : 0;
  endfunction

  // Highest operand index that contributes to product coefficient k.
  function automatic int pp_hi(int k, int m);
    return (k < m - 1) ? k : (m - 1);
  endfunction

endpackage

// File: rtl/gf2_xor_tree.sv
// Balanced parity tree of two-input XOR gates; depth is ceil(log2(N)).
module gf2_xor_tree #(
  parameter int N = 4
) (
  input  logic [N-1:0] d_i,
  output logic         y_o
);
  localparam int LV = $clog2(N);
  localparam int P2 = 1 << LV;

  for (genvar k = 0; k <= LV; k++) begin : lv_g
    localparam int W = P2 >> k;
    logic [W-1:0] v;
    if (k == 0) begin : g_leaf
      assign v = W'(d_i);
    end else begin : g_node
      for (genvar i = 0; i < W; i++) begin : g_x
        assign v[i] = lv_g[k-1].v[2*i] ^ lv_g[k-1].v[2*i+1];
      end
    end
  end

  assign y_o = lv_g[LV].v[0];
endmodule

// File: rtl/gf2m_pmul.sv
// Carry-less product: AND array, one XOR tree per product coefficient.
module gf2m_pmul
  import gf2m_pkg::*;
#(
  parameter int M = 8
) (
  input  logic [M-1:0]   a_i,
  input  logic [M-1:0]   b_i,
  output logic [2*M-2:0] p_o
);
  localparam int PW = 2 * M - 1;

  for (genvar k = 0; k < PW; k++) begin : coef_g
    localparam int LO  = pp_lo(k, M);
    localparam int HI  = pp_hi(k, M);
    localparam int CNT = HI - LO + 1;
    logic [CNT-1:0] term;
    for (genvar j = 0; j < CNT; j++) begin : and_g
      assign term[j] = a_i[LO+j] & b_i[k-LO-j];
    end
    gf2_xor_tree #(.N(CNT)) u_sum (
      .d_i (term),
      .y_o (p_o[k])
    );
  end
endmodule

// File: rtl/gf2m_reduce.sv
// Folds coefficients M..2M-2 back into M bits through a fixed fold map.
module gf2m_reduce
  import gf2m_pkg::*;
#(
  parameter int      M    = 8,
  parameter gf_row_t TAPS = 32'h1B
) (
  input  logic [2*M-2:0] p_i,
  output logic [M-1:0]   c_o
);
  localparam int UPN = M - 1;

  for (genvar i = 0; i < M; i++) begin : out_g
    logic [UPN:0] sel;
    assign sel[0] = p_i[i];
    for (genvar j = 0; j < UPN; j++) begin : up_g
      localparam gf_row_t ROW = fold_row(M, TAPS, j);
      if (ROW[i]) begin : g_tap
        assign sel[j+1] = p_i[M+j];
      end else begin : g_none
        assign sel[j+1] = 1'b0;
      end
    end
    gf2_xor_tree #(.N(UPN + 1)) u_fold (
      .d_i (sel),
      .y_o (c_o[i])
    );
  end
endmodule

// File: rtl/gf2m_ostage.sv
// Reset release synchroniser plus optional result register.
module gf2m_ostage #(
  parameter int M       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [M-1:0] d_i,
  output logic         vld_o,
  output logic [M-1:0] d_o
);
  logic rel_q1;
  logic rel_q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q1 <= 1'b0;
      rel_q2 <= 1'b0;
    end else begin
      rel_q1 <= 1'b1;
      rel_q2 <= rel_q1;
    end
  end

  if (REG_OUT) begin : g_reg
    logic         vld_d;
    logic         vld_q;
    logic         cap_en;
    logic [M-1:0] res_d;
    logic [M-1:0] res_q;

    always_comb begin
      vld_d  = vld_i;
      cap_en = vld_i;
      res_d  = d_i;
    end

    always_ff @(posedge clk or negedge rel_q2) begin
      if (!rel_q2) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else begin
        vld_q <= vld_d;
        if (cap_en) res_q <= res_d;
      end
    end

    assign vld_o = vld_q;
    assign d_o   = res_q;
  end else begin : g_comb
    assign vld_o = vld_i & rel_q2;
    assign d_o   = d_i;
  end
endmodule

// File: rtl/gf2m_mult_top.sv
module gf2m_mult_top
  import gf2m_pkg::*;
#(
  parameter int      M       = 8,
  parameter gf_row_t TAPS    = 32'h1B,
  parameter bit      REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic         out_valid,
  output logic [M-1:0] c_o
);
  localparam int PW = 2 * M - 1;

  logic [PW-1:0] raw_prod;
  logic [M-1:0]  red_prod;

  gf2m_pmul #(.M(M)) u_pmul (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (raw_prod)
  );

  gf2m_reduce #(.M(M), .TAPS(TAPS)) u_reduce (
    .p_i (raw_prod),
    .c_o (red_prod)
  );

  gf2m_ostage #(.M(M), .REG_OUT(REG_OUT)) u_ostage (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_valid),
    .d_i   (red_prod),
    .vld_o (out_valid),
    .d_o   (c_o)
  );
endmodule

// File: rtl/gf2m_mult_chk.sv
module gf2m_mult_chk #(
  parameter int M       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [M-1:0] a_i,
  input logic [M-1:0] b_i,
  input logic         out_valid,
  input logic [M-1:0] c_o
);
  if (REG_OUT) begin : g_reg
    // R9
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
    // R10
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(c_o));
    // R6
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(a_i) == '0) |-> c_o == '0);
    // R7
    unit_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(a_i) == M'(1)) |-> c_o == $past(b_i));
  end else begin : g_comb
    // R6
    zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_i == '0 |-> c_o == '0);
    // R6
    zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_i == '0 |-> c_o == '0);
    // R7
    unit_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_i == M'(1) |-> c_o == b_i);
  end
endmodule

bind gf2m_mult_top gf2m_mult_chk #(.M(M), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .a_i       (a_i),
  .b_i       (b_i),
  .out_valid (out_valid),
  .c_o       (c_o)
);

// File: tb/tb_gf2m_mult_top.sv
module tb_gf2m_mult_top;
  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  int   total;
  int   bad;

  logic       v8, ov8;
  logic [7:0] a8, b8, c8;
  logic       v6, ov6;
  logic [5:0] a6, b6, c6;
  logic       v7, ov7a, ov7b;
  logic [6:0] a7, b7, c7a, c7b;

  gf2m_mult_top #(.M(8), .TAPS(32'h1B), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .a_i(a8), .b_i(b8),
    .out_valid(ov8), .c_o(c8));
  gf2m_mult_top #(.M(6), .TAPS(32'h09), .REG_OUT(1'b0)) dut6 (
    .clk(clk), .rst_n(rst_n), .in_valid(v6), .a_i(a6), .b_i(b6),
    .out_valid(ov6), .c_o(c6));
  gf2m_mult_top #(.M(7), .TAPS(32'h11), .REG_OUT(1'b0)) dut7a (
    .clk(clk), .rst_n(rst_n), .in_valid(v7), .a_i(a7), .b_i(b7),
    .out_valid(ov7a), .c_o(c7a));
  gf2m_mult_top #(.M(7), .TAPS(32'h09), .REG_OUT(1'b0)) dut7b (
    .clk(clk), .rst_n(rst_n), .in_valid(v7), .a_i(a7), .b_i(b7),
    .out_valid(ov7b), .c_o(c7b));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Shift-and-reduce model; poly includes the x^m term.
  function automatic logic [31:0] ref_mul(int unsigned a, int unsigned b,
                                          int m, int unsigned poly);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < m; i++)
      if (b[i]) r = r ^ (32'(a) << i);
    for (int k = 2 * m - 2; k >= m; k--)
      if (r[k]) r = r ^ (32'(poly) << (k - m));
    return r;
  endfunction

  function automatic string tag(int unsigned a, int unsigned b, string dflt);
    if (a == 0 || b == 0) return "R6";
    if (a == 1 || b == 1) return "R7";
    return dflt;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic reg_op(string req, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    v8 = 1'b1; a8 = a; b8 = b;
    @(negedge clk);
    chk(req, 32'(c8), ref_mul(a, b, 8, 32'h11B));
    chk("R9", 32'(ov8), 32'd1);
    v8 = 1'b0;
  endtask

  task automatic hold_op(logic [7:0] a, logic [7:0] b);
    logic [7:0] prev;
    @(negedge clk);
    prev = c8;
    v8 = 1'b0; a8 = a; b8 = b;
    @(negedge clk);
    chk("R10", 32'(c8), 32'(prev));
    chk("R10", 32'(ov8), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0;
    v8 = 1'b0; a8 = '0; b8 = '0;
    v6 = 1'b0; a6 = '0; b6 = '0;
    v7 = 1'b0; a7 = '0; b7 = '0;
    repeat (3) @(negedge clk);
    v8 = 1'b1; a8 = 8'h01; b8 = 8'h05;
    v6 = 1'b1; v7 = 1'b1;
    @(negedge clk);
    // R11: outputs held low during reset
    chk("R11", 32'(ov8), 32'd0);
    chk("R11", 32'(c8), 32'd0);
    chk("R11", 32'(ov6), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", 32'(ov6), 32'd0);
    chk("R11", 32'(ov8), 32'd0);
    @(negedge clk);
    chk("R11", 32'(ov6), 32'd1);
    chk("R11", 32'(ov8), 32'd0);
    @(negedge clk);
    chk("R11", 32'(ov8), 32'd1);
    chk("R9", 32'(c8), 32'h05);
    v8 = 1'b0;

    // R2, R3, R4: exhaustive sweeps of the combinational builds
    for (int a = 0; a < 128; a++) begin
      for (int b = 0; b < 128; b++) begin
        @(negedge clk);
        a7 = 7'(a); b7 = 7'(b);
        a6 = 6'(a); b6 = 6'(b);
        #1;
        chk(tag(a, b, "R3"), 32'(c7a), ref_mul(a, b, 7, 32'h91));
        chk(tag(a, b, "R4"), 32'(c7b), ref_mul(a, b, 7, 32'h89));
        if (a < 64 && b < 64)
          chk(tag(a, b, "R2"), 32'(c6), ref_mul(a, b, 6, 32'h49));
      end
    end

    // R5: known vectors and bit order
    reg_op("R5", 8'h57, 8'h83);
    chk("R5", 32'(c8), 32'hC1);
    reg_op("R5", 8'h57, 8'h13);
    chk("R5", 32'(c8), 32'hFE);
    reg_op("R5", 8'h02, 8'h80);
    chk("R5", 32'(c8), 32'h1B);

    // R6, R7 on the registered build
    for (int i = 0; i < 16; i++) begin
      logic [7:0] x;
      x = 8'($urandom);
      reg_op("R6", 8'h00, x);
      reg_op("R6", x, 8'h00);
      reg_op("R7", 8'h01, x);
      chk("R7", 32'(c8), 32'(x));
      reg_op("R7", x, 8'h01);
      chk("R7", 32'(c8), 32'(x));
    end

    // R1, R8: random pairs and swapped order; R10 holds in between
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] x;
      logic [7:0] y;
      logic [7:0] first;
      x = 8'($urandom);
      y = 8'($urandom);
      reg_op("R1", x, y);
      first = c8;
      reg_op("R8", y, x);
      chk("R8", 32'(c8), 32'(first));
      if (i % 8 == 0) hold_op(~x, ~y);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule